// File: doc/BRIEF.md
# Non-Destructive Memory Size Probe

This block works out how much RAM really answers inside a window of `MAX_WORDS` words that starts at `BASE_ADDR`. It drives a word-wide synchronous memory port as its only master. It marks every power-of-two word offset with a value unique to that offset. It clears the base word, then reads the marks back. The first offset that does not return its own mark shows where the address space folds back onto itself or stops answering. A shorted or missing address line looks the same way, because a later write to a lower offset lands on a higher one.

Each word is read and saved before the block writes to it. Once the size is known, the block writes every saved value back in the exact reverse order of its own writes, so memory ends as it began, even when locations alias each other. A start pulse launches one probe. A one-cycle done pulse ends it, and the size in bytes then stays on the output until the next probe changes it.

State sequence: `ST_IDLE` -> (start) `ST_SAVE_RD` -> (grant) `ST_SAVE_WAIT` -> (read valid) `ST_MARK_WR` -> (grant, offset above 1) `ST_SAVE_RD` or (grant, offset 1) `ST_BASE_RD` -> `ST_BASE_WAIT` -> `ST_ZERO_WR` -> `ST_CHK_RD` -> `ST_CHK_WAIT` -> (base non-zero) `ST_REST_BASE` or (base zero) `ST_VFY_RD` -> `ST_VFY_WAIT` -> (match, not top) `ST_VFY_RD` or (mismatch or top offset) `ST_REST_BASE` -> `ST_REST_WR` -> (last offset written) `ST_DONE` -> `ST_IDLE`.

Top module: `mem_size_probe`

## Requirements
- R1: While reset is asserted and after it is released, `mem_req`, `done` and `size_bytes` are all 0.
- R2: The marking pass visits word offsets MAX_WORDS, MAX_WORDS/2, ... down to 1. At each offset it first reads the word and then writes the bitwise inverse of the offset, zero-extended to DATA_W bits. The address is BASE_ADDR plus the offset.
- R3: After the marking pass, the block reads the base word, writes 0 to it, and reads it back once.
- R4: If that base readback is non-zero, `size_bytes` becomes 0 and no verify reads follow. The block goes straight to restore.
- R5: Otherwise the verify pass reads offsets 1, 2, 4, ... upward with no writes in between. At the first offset whose data differs from the inverse of that offset, it stops and `size_bytes` becomes offset × DATA_W/8.
- R6: If every offset up to MAX_WORDS returns its mark, `size_bytes` becomes MAX_WORDS × DATA_W/8.
- R7: Restore writes the saved base value to the base, then writes each offset's saved value at offsets 1, 2, ... MAX_WORDS. Afterwards every word the probe touched holds its value from before the probe, aliasing included.
- R8: While `mem_req` is high and `mem_gnt` is low, the request stays high on the next cycle with `mem_addr`, `mem_we` and `mem_wdata` unchanged.
- R9: `done` is high for exactly one cycle, in the cycle after the final restore write is granted. `size_bytes` does not change while the block is idle.
- R10: `start` is acted on only in the idle state. A start that arrives during a probe, including the cycle in which `done` is high, causes no memory access and no change of `size_bytes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch one probe when idle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid, one cycle after a granted read |
| mem_rdata | input | DATA_W | Read data |
| done | output | 1 | One-cycle end-of-probe pulse |
| size_bytes | output | log2(MAX_WORDS)+log2(DATA_W/8)+1 | Detected size in bytes |

## Verification
Two functions can fall in the same cycle. The completion pulse can coincide with a fresh `start`, and the probe's own detection can coincide with aliasing, where a mark written at one offset overwrites the mark or the zeroed base of another. The bench raises `start` exactly in the `done` cycle and in the middle of a probe. It then checks that no further access appears, using its transaction queue, and that `size_bytes` stays put. It runs memories that fold at 1, 2, 64 and 128 words, and one whose base ignores writes. For each, a behavioural model predicts every access, the size, and a final memory image equal to the starting one, and grants are stalled on some cycles to exercise held requests.

// File: rtl/mszp_pkg.sv
package mszp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SAVE_RD,
        ST_SAVE_WAIT,
        ST_MARK_WR,
        ST_BASE_RD,
        ST_BASE_WAIT,
        ST_ZERO_WR,
        ST_CHK_RD,
        ST_CHK_WAIT,
        ST_VFY_RD,
        ST_VFY_WAIT,
        ST_REST_BASE,
        ST_REST_WR,
        ST_DONE
    } probe_state_e;

endpackage

// File: rtl/mszp_pattern.sv
// Offset arithmetic for one power-of-two probe point: its word address,
// its mark value and its size in bytes.
module mszp_pattern #(
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 12,
    parameter int          EXP_W     = 4,
    parameter int          OFF_W     = 9,
    parameter int          BPW_LOG   = 2,
    parameter int          SIZE_W    = 11,
    parameter int unsigned BASE_ADDR = 0
) (
    input  logic [EXP_W-1:0]  exp_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] mark_o,
    output logic [SIZE_W-1:0] bytes_o
);

    logic [OFF_W-1:0] offset;

    assign offset  = OFF_W'(1) << exp_i;
    assign addr_o  = ADDR_W'(BASE_ADDR) + ADDR_W'(offset);
    assign mark_o  = ~DATA_W'(offset);
    assign bytes_o = SIZE_W'(offset) << BPW_LOG;

endmodule

// File: rtl/mszp_save_buf.sv
// Holding store for original memory contents: one slot per probe offset
// (indexed by the offset's exponent) plus a final slot for the base word.
module mszp_save_buf #(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 10,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(s))) begin
                slot_q[s] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (rd_idx == IDX_W'(s)) begin
                rd_data = slot_q[s];
            end
        end
    end

endmodule

// File: rtl/mem_size_probe.sv
module mem_size_probe
    import mszp_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 12,
    parameter int          MAX_WORDS = 256,
    parameter int unsigned BASE_ADDR = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic                  mem_gnt,
    input  logic                  mem_rvalid,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  done,
    output logic [$clog2(MAX_WORDS)+$clog2(DATA_W/8):0] size_bytes
);

    localparam int LOG_MAX = $clog2(MAX_WORDS);
    localparam int OFF_W   = LOG_MAX + 1;
    localparam int EXP_W   = (LOG_MAX < 1) ? 1 : $clog2(LOG_MAX + 1);
    localparam int SLOTS   = LOG_MAX + 2;
    localparam int IDX_W   = $clog2(SLOTS);
    localparam int BPW     = DATA_W / 8;
    localparam int BPW_LOG = $clog2(BPW);
    localparam int SIZE_W  = OFF_W + BPW_LOG;

    localparam logic [EXP_W-1:0]  EXP_TOP    = EXP_W'(LOG_MAX);
    localparam logic [IDX_W-1:0]  BASE_SLOT  = IDX_W'(SLOTS - 1);
    localparam logic [SIZE_W-1:0] FULL_BYTES = SIZE_W'(MAX_WORDS * BPW);
    localparam logic [ADDR_W-1:0] BASE_WA    = ADDR_W'(BASE_ADDR);

    probe_state_e state_q, state_d;

    logic [EXP_W-1:0]  exp_q;
    logic [SIZE_W-1:0] size_q;

    logic [ADDR_W-1:0] off_addr;
    logic [DATA_W-1:0] off_mark;
    logic [SIZE_W-1:0] off_bytes;

    logic              sb_wr_en;
    logic [IDX_W-1:0]  sb_wr_idx;
    logic [IDX_W-1:0]  sb_rd_idx;
    logic [DATA_W-1:0] sb_rd_data;

    logic at_top;
    logic at_bottom;
    logic mark_miss;

    assign at_top    = (exp_q == EXP_TOP);
    assign at_bottom = (exp_q == '0);
    assign mark_miss = (mem_rdata != off_mark);

    mszp_pattern #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .EXP_W     (EXP_W),
        .OFF_W     (OFF_W),
        .BPW_LOG   (BPW_LOG),
        .SIZE_W    (SIZE_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_pattern (
        .exp_i   (exp_q),
        .addr_o  (off_addr),
        .mark_o  (off_mark),
        .bytes_o (off_bytes)
    );

    // Save slots: written as each original word comes back, read on restore.
    assign sb_wr_en  = mem_rvalid && ((state_q == ST_SAVE_WAIT) || (state_q == ST_BASE_WAIT));
    assign sb_wr_idx = (state_q == ST_BASE_WAIT) ? BASE_SLOT : IDX_W'(exp_q);
    assign sb_rd_idx = (state_q == ST_REST_BASE) ? BASE_SLOT : IDX_W'(exp_q);

    mszp_save_buf #(
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS),
        .IDX_W  (IDX_W)
    ) u_save (
        .clk     (clk),
        .wr_en   (sb_wr_en),
        .wr_idx  (sb_wr_idx),
        .wr_data (mem_rdata),
        .rd_idx  (sb_rd_idx),
        .rd_data (sb_rd_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start)      state_d = ST_SAVE_RD;
            ST_SAVE_RD:   if (mem_gnt)    state_d = ST_SAVE_WAIT;
            ST_SAVE_WAIT: if (mem_rvalid) state_d = ST_MARK_WR;
            ST_MARK_WR:   if (mem_gnt)    state_d = at_bottom ? ST_BASE_RD : ST_SAVE_RD;
            ST_BASE_RD:   if (mem_gnt)    state_d = ST_BASE_WAIT;
            ST_BASE_WAIT: if (mem_rvalid) state_d = ST_ZERO_WR;
            ST_ZERO_WR:   if (mem_gnt)    state_d = ST_CHK_RD;
            ST_CHK_RD:    if (mem_gnt)    state_d = ST_CHK_WAIT;
            ST_CHK_WAIT:  if (mem_rvalid) state_d = (mem_rdata != '0) ? ST_REST_BASE : ST_VFY_RD;
            ST_VFY_RD:    if (mem_gnt)    state_d = ST_VFY_WAIT;
            ST_VFY_WAIT:  if (mem_rvalid) state_d = (mark_miss || at_top) ? ST_REST_BASE : ST_VFY_RD;
            ST_REST_BASE: if (mem_gnt)    state_d = ST_REST_WR;
            ST_REST_WR:   if (mem_gnt && at_top) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Offset exponent and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q  <= '0;
            size_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) exp_q <= EXP_TOP;
                end
                ST_MARK_WR: begin
                    if (mem_gnt && !at_bottom) exp_q <= exp_q - 1'b1;
                end
                ST_CHK_WAIT: begin
                    if (mem_rvalid) begin
                        exp_q <= '0;
                        if (mem_rdata != '0) size_q <= '0;
                    end
                end
                ST_VFY_WAIT: begin
                    if (mem_rvalid) begin
                        if (mark_miss)   size_q <= off_bytes;
                        else if (at_top) size_q <= FULL_BYTES;
                        else             exp_q  <= exp_q + 1'b1;
                    end
                end
                ST_REST_BASE: begin
                    if (mem_gnt) exp_q <= '0;
                end
                ST_REST_WR: begin
                    if (mem_gnt && !at_top) exp_q <= exp_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        unique case (state_q)
            ST_SAVE_RD, ST_VFY_RD: begin
                mem_req  = 1'b1;
                mem_addr = off_addr;
            end
            ST_MARK_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = off_addr;
                mem_wdata = off_mark;
            end
            ST_BASE_RD, ST_CHK_RD: begin
                mem_req  = 1'b1;
                mem_addr = BASE_WA;
            end
            ST_ZERO_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = BASE_WA;
            end
            ST_REST_BASE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = BASE_WA;
                mem_wdata = sb_rd_data;
            end
            ST_REST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = off_addr;
                mem_wdata = sb_rd_data;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign size_bytes = size_q;

endmodule

// File: rtl/mszp_checker.sv
module mszp_checker
    import mszp_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 12,
    parameter int SIZE_W     = 11,
    parameter int FULL_BYTES = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              done,
    input logic [SIZE_W-1:0] size_bytes,
    input probe_state_e      state_q
);

    // R8: an ungranted request is held unchanged
    p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: completion follows a granted restore write
    p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_we && mem_gnt));

    // R9: result held while idle
    p_size_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(size_bytes));

    // R10: a start in the completion cycle does not launch a probe
    p_done_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

    // R4: non-zero base readback forces size 0 and skips verification
    p_base_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHK_WAIT && mem_rvalid && mem_rdata != '0)
            |=> (size_bytes == '0 && state_q == ST_REST_BASE));

    // R6: the size never exceeds the window
    p_size_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        size_bytes <= SIZE_W'(FULL_BYTES));

endmodule

bind mem_size_probe mszp_checker #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .SIZE_W     ($clog2(MAX_WORDS) + $clog2(DATA_W/8) + 1),
    .FULL_BYTES (MAX_WORDS * (DATA_W/8))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .done       (done),
    .size_bytes (size_bytes),
    .state_q    (state_q)
);

// File: tb/mem_size_probe_bench.sv
module mem_size_probe_bench;

    localparam int DW   = 32;
    localparam int AW   = 12;
    localparam int MW   = 256;
    localparam int LOGM = 8;
    localparam int BPW  = 4;
    localparam int SZW  = 11;
    localparam int PHYS = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    always #5 clk = ~clk;

    logic           mem_req, mem_we, mem_gnt, mem_rvalid, done;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata, mem_rdata;
    logic [SZW-1:0] size_bytes;

    mem_size_probe #(.DATA_W(DW), .ADDR_W(AW), .MAX_WORDS(MW), .BASE_ADDR(0)) u_mem_size_probe (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .size_bytes(size_bytes)
    );

    int total = 0;
    int bad   = 0;
    int phys_words = PHYS;
    bit stuck_base = 1'b0;
    int stall_mode = 0;
    int cyc = 0;

    logic [31:0] phys [PHYS];
    logic [31:0] snap [PHYS];
    logic [31:0] rm   [PHYS];
    logic [31:0] sv   [LOGM+1];

    bit          q_we   [$];
    int          q_addr [$];
    logic [31:0] q_data [$];
    string       q_tag  [$];
    int          exp_size;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural memory: folds addresses at phys_words, optional dead base.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rvalid <= 1'b0;
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                if (!(stuck_base && ((int'(mem_addr) & (phys_words - 1)) == 0)))
                    phys[int'(mem_addr) & (phys_words - 1)] <= mem_wdata;
            end else begin
                mem_rdata  <= phys[int'(mem_addr) & (phys_words - 1)];
                mem_rvalid <= 1'b1;
            end
        end
        mem_gnt <= (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    end

    // Reference model helpers
    function automatic logic [31:0] ref_rd(input int a);
        return rm[a & (phys_words - 1)];
    endfunction

    task automatic ref_wr(input int a, input logic [31:0] d);
        if (!(stuck_base && ((a & (phys_words - 1)) == 0))) rm[a & (phys_words - 1)] = d;
    endtask

    task automatic push_op(input bit we, input int a, input logic [31:0] d, input string t);
        q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
    endtask

    task automatic build_ref();
        logic [31:0] sb, v;
        bit found;
        // R2: descending marking pass
        for (int e = LOGM; e >= 0; e--) begin
            int off = 1 << e;
            push_op(1'b0, off, 32'h0, "R2");
            sv[e] = ref_rd(off);
            push_op(1'b1, off, ~32'(off), "R2");
            ref_wr(off, ~32'(off));
        end
        // R3: base save, clear, recheck
        push_op(1'b0, 0, 32'h0, "R3");
        sb = ref_rd(0);
        push_op(1'b1, 0, 32'h0, "R3");
        ref_wr(0, 32'h0);
        push_op(1'b0, 0, 32'h0, "R3");
        v = ref_rd(0);
        if (v != 32'h0) begin
            exp_size = 0;                      // R4
        end else begin
            found = 1'b0;
            for (int e = 0; e <= LOGM && !found; e++) begin
                int off = 1 << e;
                push_op(1'b0, off, 32'h0, "R5");
                v = ref_rd(off);
                if (v != ~32'(off)) begin
                    exp_size = off * BPW;      // R5
                    found = 1'b1;
                end else if (e == LOGM) begin
                    exp_size = MW * BPW;       // R6
                end
            end
        end
        // R7: undo in reverse write order
        push_op(1'b1, 0, sb, "R7");
        for (int e = 0; e <= LOGM; e++) push_op(1'b1, 1 << e, sv[e], "R7");
    endtask

    // Per-clock comparison of the port activity against the model
    bit          prev_stall = 1'b0;
    logic [AW-1:0] prev_addr;
    bit          prev_we;
    logic [31:0] prev_wd;
    bit          h_we;
    int          h_addr;
    logic [31:0] h_data;
    string       h_tag;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wd,
                      "R8", "held request", {mem_req, mem_we, mem_addr}, {1'b1, prev_we, prev_addr});
            prev_stall = mem_req && !mem_gnt;
            prev_addr  = mem_addr;
            prev_we    = mem_we;
            prev_wd    = mem_wdata;
            if (mem_req && mem_gnt) begin
                if (q_we.size() == 0) begin
                    check(1'b0, "R10", "access with none expected", mem_addr, 0);
                end else begin
                    h_we = q_we.pop_front(); h_addr = q_addr.pop_front();
                    h_data = q_data.pop_front(); h_tag = q_tag.pop_front();
                    check(mem_we == h_we && int'(mem_addr) == h_addr && (!h_we || mem_wdata == h_data),
                          h_tag, "access (we,addr,wdata)",
                          {mem_we, mem_addr, mem_wdata},
                          {h_we, AW'(h_addr), (h_we ? h_data : mem_wdata)});
                end
            end
        end
    end

    task automatic run_case(input int p, input bit stk, input int sm, input int seed, input bit poke_busy);
        int n;
        int diffs;
        logic [SZW-1:0] held;
        string stag;
        @(negedge clk);
        phys_words = p;
        stuck_base = stk;
        stall_mode = sm;
        for (int i = 0; i < PHYS; i++) begin
            logic [31:0] val = 32'h5A000001 ^ (i * 32'h00010203) ^ (seed * 32'h01000000);
            phys[i] <= val;
            snap[i] = val;
            rm[i]   = val;
        end
        build_ref();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            repeat (15) @(negedge clk);
            start = 1'b1;                      // R10: ignored mid-probe
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R9", "done reached", done, 1);
        stag = (exp_size == 0) ? "R4" : ((exp_size == MW * BPW) ? "R6" : "R5");
        check(size_bytes == SZW'(exp_size), stag, "size_bytes", size_bytes, exp_size);
        check(q_we.size() == 0, "R7", "accesses left unissued", q_we.size(), 0);
        held  = size_bytes;
        start = 1'b1;                          // R10: start in the done cycle
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R9", "done pulse width", done, 0);
        for (int k = 0; k < 8; k++) begin
            check(!mem_req && size_bytes == held, "R10", "quiet after done-cycle start",
                  {mem_req, size_bytes}, {1'b0, held});
            @(negedge clk);
        end
        diffs = 0;
        for (int i = 0; i < p; i++) if (phys[i] != snap[i]) diffs++;
        check(diffs == 0, "R7", "words changed by probe", diffs, 0);
        q_we.delete(); q_addr.delete(); q_data.delete(); q_tag.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!mem_req && !done && size_bytes == '0, "R1", "outputs in reset",
              {mem_req, done, size_bytes}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req && !done && size_bytes == '0, "R1", "outputs after reset",
              {mem_req, done, size_bytes}, 0);
        run_case(512, 1'b0, 0, 1, 1'b0);   // R6 full window
        run_case(64,  1'b0, 1, 2, 1'b1);   // R5 fold at 64, stalls, busy start
        run_case(2,   1'b0, 0, 3, 1'b0);   // R5 fold at 2
        run_case(1,   1'b0, 1, 4, 1'b0);   // R5 single word
        run_case(512, 1'b1, 1, 5, 1'b0);   // R4 dead base
        run_case(128, 1'b0, 1, 6, 1'b0);   // R5 fold at 128
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule